// File: doc/BRIEF.md
# Rotating Multi-Context Processor Core

This block runs several independent small processors on one shared execution unit. Each context has its own program counter, its own 18-bit accumulator, its own halt flag and its own word memory of 12-bit words. A turn pointer visits the contexts in a fixed circular order, one context per clock. On its turn, a context fetches one instruction from its own memory and the shared unit executes it against that context's state. No context can stall or skip another.

The instruction set is small on purpose. It has load-immediate, add-from-memory, store-to-memory, jump and halt, and every other opcode acts as a no-op. A debug port loads the context memories while the core is stopped. The same port reads out the program counter, accumulator and halt flag of any chosen context. The `run` input gates both the rotation and execution, so software can load programs, start the core, stop it and inspect the results.

Each memory holds 2^`MEM_AW` words. With `MEM_AW` = 12 this is the full 4096-word space. The default configuration uses a smaller memory so that it stays cheap to elaborate.

Top module: `barrel_core`

## Requirements
- R1: After reset, `cur_ctx` is 0. Every context has program counter 0, accumulator 0 and its halt flag clear. Memory contents are not altered by reset.
- R2: While `run` is high, `cur_ctx` steps by one on each clock and wraps from `N_CTX`-1 to 0. Every context gets a turn in every rotation, halted ones included. `N_CTX` must be 10, 14, 17 or 20.
- R3: One turn executes exactly one instruction, taken from the current context's own memory at its own program counter. A run of `N_CTX` clocks therefore advances each non-halted context by exactly one instruction.
- R4: An instruction word carries the opcode in bits [11:6] and the operand in bits [5:0]. Opcode 0x01 (load) sets the accumulator to the zero-extended operand.
- R5: Opcode 0x02 (add) adds the context-memory word at the address given by the operand to the accumulator, modulo 2^18.
- R6: Opcode 0x03 (store) writes accumulator bits [11:0] to the context's own memory at the operand address. The memories of other contexts are not changed.
- R7: Opcode 0x04 (jump) loads the operand into the program counter.
- R8: Opcode 0x00 (halt) sets the halt flag and leaves the program counter on the halt word. A halted context changes no state on its later turns until reset. Any opcode not listed here only advances the program counter.
- R9: The program counter is `MEM_AW` bits wide and wraps modulo 2^`MEM_AW`. That is 4096 for `MEM_AW` = 12.
- R10: While `run` is low, `cur_ctx` holds and no instruction executes. Debug writes take effect only while `run` is low and are ignored while it is high.
- R11: `dbg_pc`, `dbg_acc` and `dbg_halt` show, without delay, the state of the context selected by `dbg_ctx`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| run | input | 1 | Enables rotation and execution |
| dbg_we | input | 1 | Debug memory write strobe (honoured only while stopped) |
| dbg_ctx | input | $clog2(N_CTX) | Context selected for debug write and readout |
| dbg_addr | input | MEM_AW | Debug write address |
| dbg_wdata | input | 12 | Debug write data |
| cur_ctx | output | $clog2(N_CTX) | Context whose turn it is |
| dbg_pc | output | MEM_AW | Program counter of the selected context |
| dbg_acc | output | 18 | Accumulator of the selected context |
| dbg_halt | output | 1 | Halt flag of the selected context |

## Verification
The assertions assume that `rst`, `run` and all debug inputs change only between clock edges. They also assume that `dbg_ctx` names an existing context whenever its readout is being compared across cycles. The bench drives every input on the falling edge and only ever selects contexts below `N_CTX`. It writes program memory only while `run` is low, except in the one scenario that deliberately tries a write during execution. Each scenario preloads every word its programs fetch or read, so no result depends on uninitialised memory.

// File: rtl/barrel_pkg.sv
package barrel_pkg;
  localparam int WORD_W = 12;
  localparam int ACC_W  = 18;
  localparam int OPC_W  = 6;
  localparam int OPD_W  = 6;

  typedef enum logic [OPC_W-1:0] {
    OP_HLT = 6'h00,
    OP_LDI = 6'h01,
    OP_ADD = 6'h02,
    OP_STO = 6'h03,
    OP_JMP = 6'h04
  } opcode_e;

  function automatic logic [OPC_W-1:0] opc_of(input logic [WORD_W-1:0] w);
    return w[WORD_W-1 -: OPC_W];
  endfunction

  function automatic logic [OPD_W-1:0] opd_of(input logic [WORD_W-1:0] w);
    return w[OPD_W-1:0];
  endfunction

  function automatic logic [ACC_W-1:0] acc_add(input logic [ACC_W-1:0] a,
                                               input logic [WORD_W-1:0] w);
    return a + {{(ACC_W-WORD_W){1'b0}}, w};
  endfunction
endpackage

// File: rtl/barrel_turn.sv
module barrel_turn #(
  parameter int N_CTX = 10,
  localparam int CTX_W = $clog2(N_CTX)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             run,
  output logic [CTX_W-1:0] turn
);
  localparam logic [CTX_W-1:0] LAST = CTX_W'(N_CTX - 1);

  always_ff @(posedge clk) begin
    if (rst)
      turn <= '0;
    else if (run)
      turn <= (turn == LAST) ? '0 : turn + 1'b1;
  end
endmodule

// File: rtl/barrel_ctx_bank.sv
module barrel_ctx_bank
  import barrel_pkg::*;
#(
  parameter int MEM_AW = 8,
  localparam int DEPTH = 1 << MEM_AW
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              commit,
  input  logic [MEM_AW-1:0] nxt_pc,
  input  logic [ACC_W-1:0]  nxt_acc,
  input  logic              set_halt,
  input  logic              st_en,
  input  logic [MEM_AW-1:0] st_addr,
  input  logic [WORD_W-1:0] st_data,
  input  logic              dbg_we,
  input  logic [MEM_AW-1:0] dbg_addr,
  input  logic [WORD_W-1:0] dbg_wdata,
  output logic [WORD_W-1:0] instr,
  output logic [WORD_W-1:0] opd_word,
  output logic [MEM_AW-1:0] pc,
  output logic [ACC_W-1:0]  acc,
  output logic              halted
);
  logic [WORD_W-1:0] mem [DEPTH];
  logic [MEM_AW-1:0] opd_addr;

  assign instr    = mem[pc];
  assign opd_addr = MEM_AW'(opd_of(instr));
  assign opd_word = mem[opd_addr];

  always_ff @(posedge clk) begin
    if (commit && st_en)
      mem[st_addr] <= st_data;
    else if (dbg_we)
      mem[dbg_addr] <= dbg_wdata;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      pc     <= '0;
      acc    <= '0;
      halted <= 1'b0;
    end else if (commit) begin
      pc  <= nxt_pc;
      acc <= nxt_acc;
      if (set_halt)
        halted <= 1'b1;
    end
  end
endmodule

// File: rtl/barrel_exec.sv
module barrel_exec
  import barrel_pkg::*;
#(
  parameter int MEM_AW = 8
) (
  input  logic [WORD_W-1:0] instr,
  input  logic [WORD_W-1:0] opd_word,
  input  logic [MEM_AW-1:0] pc,
  input  logic [ACC_W-1:0]  acc,
  input  logic              halted,
  output logic [MEM_AW-1:0] nxt_pc,
  output logic [ACC_W-1:0]  nxt_acc,
  output logic              set_halt,
  output logic              st_en,
  output logic [MEM_AW-1:0] st_addr,
  output logic [WORD_W-1:0] st_data
);
  logic [OPC_W-1:0] opc;
  logic [OPD_W-1:0] opd;

  assign opc = opc_of(instr);
  assign opd = opd_of(instr);

  always_comb begin
    nxt_pc   = pc + 1'b1;
    nxt_acc  = acc;
    set_halt = 1'b0;
    st_en    = 1'b0;
    st_addr  = MEM_AW'(opd);
    st_data  = acc[WORD_W-1:0];
    if (halted) begin
      nxt_pc = pc;
    end else begin
      case (opc)
        OP_LDI: nxt_acc = ACC_W'(opd);
        OP_ADD: nxt_acc = acc_add(acc, opd_word);
        OP_STO: st_en   = 1'b1;
        OP_JMP: nxt_pc  = MEM_AW'(opd);
        OP_HLT: begin
          set_halt = 1'b1;
          nxt_pc   = pc;
        end
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/barrel_core.sv
module barrel_core
  import barrel_pkg::*;
#(
  parameter int N_CTX  = 10,
  parameter int MEM_AW = 8,
  localparam int CTX_W = $clog2(N_CTX)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              run,
  input  logic              dbg_we,
  input  logic [CTX_W-1:0]  dbg_ctx,
  input  logic [MEM_AW-1:0] dbg_addr,
  input  logic [11:0]       dbg_wdata,
  output logic [CTX_W-1:0]  cur_ctx,
  output logic [MEM_AW-1:0] dbg_pc,
  output logic [17:0]       dbg_acc,
  output logic              dbg_halt
);
  logic [CTX_W-1:0]  turn;
  logic [N_CTX-1:0]  commit_vec;
  logic [WORD_W-1:0] instr_v [N_CTX];
  logic [WORD_W-1:0] opdw_v  [N_CTX];
  logic [MEM_AW-1:0] pc_v    [N_CTX];
  logic [ACC_W-1:0]  acc_v   [N_CTX];
  logic [N_CTX-1:0]  halt_v;

  logic [MEM_AW-1:0] x_nxt_pc;
  logic [ACC_W-1:0]  x_nxt_acc;
  logic              x_set_halt;
  logic              x_st_en;
  logic [MEM_AW-1:0] x_st_addr;
  logic [WORD_W-1:0] x_st_data;

  barrel_turn #(.N_CTX(N_CTX)) u_turn (
    .clk (clk),
    .rst (rst),
    .run (run),
    .turn(turn)
  );

  for (genvar i = 0; i < N_CTX; i++) begin : g_ctx
    assign commit_vec[i] = run && (turn == CTX_W'(i));

    barrel_ctx_bank #(.MEM_AW(MEM_AW)) u_bank (
      .clk      (clk),
      .rst      (rst),
      .commit   (commit_vec[i]),
      .nxt_pc   (x_nxt_pc),
      .nxt_acc  (x_nxt_acc),
      .set_halt (x_set_halt),
      .st_en    (x_st_en),
      .st_addr  (x_st_addr),
      .st_data  (x_st_data),
      .dbg_we   (dbg_we && !run && (dbg_ctx == CTX_W'(i))),
      .dbg_addr (dbg_addr),
      .dbg_wdata(dbg_wdata),
      .instr    (instr_v[i]),
      .opd_word (opdw_v[i]),
      .pc       (pc_v[i]),
      .acc      (acc_v[i]),
      .halted   (halt_v[i])
    );
  end

  barrel_exec #(.MEM_AW(MEM_AW)) u_exec (
    .instr   (instr_v[turn]),
    .opd_word(opdw_v[turn]),
    .pc      (pc_v[turn]),
    .acc     (acc_v[turn]),
    .halted  (halt_v[turn]),
    .nxt_pc  (x_nxt_pc),
    .nxt_acc (x_nxt_acc),
    .set_halt(x_set_halt),
    .st_en   (x_st_en),
    .st_addr (x_st_addr),
    .st_data (x_st_data)
  );

  assign cur_ctx  = turn;
  assign dbg_pc   = pc_v[dbg_ctx];
  assign dbg_acc  = acc_v[dbg_ctx];
  assign dbg_halt = halt_v[dbg_ctx];
endmodule

// File: rtl/barrel_core_chk.sv
module barrel_core_chk
  import barrel_pkg::*;
#(
  parameter int N_CTX  = 10,
  parameter int MEM_AW = 8,
  localparam int CTX_W = $clog2(N_CTX)
) (
  input logic              clk,
  input logic              rst,
  input logic              run,
  input logic [CTX_W-1:0]  cur_ctx,
  input logic [CTX_W-1:0]  dbg_ctx,
  input logic [MEM_AW-1:0] dbg_pc,
  input logic [ACC_W-1:0]  dbg_acc,
  input logic              dbg_halt,
  input logic [N_CTX-1:0]  commit_vec
);
  initial begin
    a_r2_ctx_count: assert (N_CTX == 10 || N_CTX == 14 || N_CTX == 17 || N_CTX == 20)
      else $error("unsupported context count %0d", N_CTX);
  end

  // R2: rotation steps by one and wraps at the last context
  a_r2_turn_step: assert property (@(posedge clk) disable iff (rst)
    run |=> (cur_ctx == (($past(cur_ctx) == CTX_W'(N_CTX - 1)) ? CTX_W'(0)
                                                               : $past(cur_ctx) + 1'b1)));

  // R10: turn pointer frozen while stopped
  a_r10_turn_hold: assert property (@(posedge clk) disable iff (rst)
    !run |=> $stable(cur_ctx));

  // R3: exactly one context commits per running cycle
  a_r3_single_slot: assert property (@(posedge clk) disable iff (rst)
    run |-> $onehot(commit_vec));

  // R8: a halted context stays halted and frozen
  a_r8_halt_frozen: assert property (@(posedge clk) disable iff (rst)
    dbg_halt ##1 $stable(dbg_ctx) |-> dbg_halt && $stable(dbg_pc) && $stable(dbg_acc));

  // R10: no state change in any context while stopped
  a_r10_stopped_frozen: assert property (@(posedge clk) disable iff (rst)
    !run ##1 $stable(dbg_ctx) |-> $stable(dbg_pc) && $stable(dbg_acc) && $stable(dbg_halt));
endmodule

bind barrel_core barrel_core_chk #(.N_CTX(N_CTX), .MEM_AW(MEM_AW)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .run       (run),
  .cur_ctx   (cur_ctx),
  .dbg_ctx   (dbg_ctx),
  .dbg_pc    (dbg_pc),
  .dbg_acc   (dbg_acc),
  .dbg_halt  (dbg_halt),
  .commit_vec(commit_vec)
);

// File: tb/tb_barrel_core.sv
`timescale 1ns/1ps
module tb_barrel_core;
  localparam int N      = 10;
  localparam int AW     = 8;
  localparam int CW     = $clog2(N);
  localparam int DEPTH  = 1 << AW;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          run = 1'b0;
  logic          dbg_we = 1'b0;
  logic [CW-1:0] dbg_ctx = '0;
  logic [AW-1:0] dbg_addr = '0;
  logic [11:0]   dbg_wdata = '0;
  logic [CW-1:0] cur_ctx;
  logic [AW-1:0] dbg_pc;
  logic [17:0]   dbg_acc;
  logic          dbg_halt;

  int n_chk = 0;
  int n_fail = 0;

  always #5 clk = ~clk;

  barrel_core #(.N_CTX(N), .MEM_AW(AW)) dut (
    .clk(clk), .rst(rst), .run(run), .dbg_we(dbg_we), .dbg_ctx(dbg_ctx),
    .dbg_addr(dbg_addr), .dbg_wdata(dbg_wdata), .cur_ctx(cur_ctx),
    .dbg_pc(dbg_pc), .dbg_acc(dbg_acc), .dbg_halt(dbg_halt)
  );

  function automatic logic [11:0] enc(input int op, input int opd);
    return {6'(op), 6'(opd)};
  endfunction

  localparam int NOP = 6'h3F;

  task automatic check(input string req, input longint act, input longint exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: got %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    run = 1'b0;
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
  endtask

  task automatic load(input int c, input int a, input logic [11:0] w);
    @(negedge clk);
    dbg_we = 1'b1; dbg_ctx = CW'(c); dbg_addr = AW'(a); dbg_wdata = w;
    @(negedge clk);
    dbg_we = 1'b0;
  endtask

  task automatic run_for(input int n);
    @(negedge clk);
    run = 1'b1;
    repeat (n) @(negedge clk);
    run = 1'b0;
  endtask

  task automatic peek(input int c);
    dbg_ctx = CW'(c);
    #1;
  endtask

  task automatic t_reset();
    rst = 1'b1;
    repeat (2) @(negedge clk);
    rst = 1'b0;
    #1;
    check("R1 cur_ctx", cur_ctx, 0);
    for (int c = 0; c < N; c++) begin
      peek(c);
      check("R1/R11 pc", dbg_pc, 0);
      check("R1/R11 acc", dbg_acc, 0);
      check("R1/R11 halt", dbg_halt, 0);
    end
  endtask

  task automatic t_rotation();
    do_reset();
    run = 1'b1;
    for (int k = 0; k < 2 * N + 3; k++) begin
      #1;
      check("R2 rotation", cur_ctx, k % N);
      @(negedge clk);
    end
    run = 1'b0;
    #1;
    begin
      int held = int'(cur_ctx);
      repeat (4) @(negedge clk);
      check("R10 turn holds when stopped", cur_ctx, held);
    end
  endtask

  task automatic t_one_per_turn();
    for (int c = 0; c < N; c++) begin
      load(c, 0, enc(6'h01, c + 1));
      load(c, 1, enc(6'h01, 50));
      load(c, 2, enc(6'h00, 0));
    end
    do_reset();
    run_for(N);
    for (int c = 0; c < N; c++) begin
      peek(c);
      check("R3/R4 acc after one turn", dbg_acc, c + 1);
      check("R3 pc after one turn", dbg_pc, 1);
    end
  endtask

  task automatic t_add_wrap();
    load(3, 0, enc(6'h02, 40));
    load(3, 1, enc(6'h04, 0));
    load(3, 40, 12'hFFF);
    do_reset();
    run_for(130 * N);
    peek(3);
    check("R5 acc wraps mod 2^18", dbg_acc, (65 * 4095) % 262144);
    check("R7 loop pc", dbg_pc, 0);
  endtask

  task automatic t_store();
    load(2, 0, enc(6'h01, 5));
    load(2, 1, enc(6'h03, 50));
    load(2, 2, enc(6'h02, 50));
    load(2, 3, enc(6'h00, 0));
    load(2, 50, 12'd0);
    load(5, 0, enc(6'h02, 50));
    load(5, 1, enc(6'h00, 0));
    load(5, 50, 12'd7);
    do_reset();
    run_for(5 * N);
    peek(2);
    check("R6 stored then added", dbg_acc, 10);
    check("R8 pc rests on halt", dbg_pc, 3);
    peek(5);
    check("R6 other context memory untouched", dbg_acc, 7);
  endtask

  task automatic t_jump();
    load(1, 0, enc(6'h04, 20));
    load(1, 1, enc(6'h01, 1));
    load(1, 20, enc(6'h01, 33));
    load(1, 21, enc(6'h00, 0));
    do_reset();
    run_for(4 * N);
    peek(1);
    check("R7 jump target executed", dbg_acc, 33);
    check("R7 pc at halt after jump", dbg_pc, 21);
    check("R8 halt flag", dbg_halt, 1);
  endtask

  task automatic t_halt();
    load(4, 0, enc(6'h01, 6));
    load(4, 1, enc(6'h00, 0));
    load(4, 2, enc(6'h01, 9));
    for (int a = 0; a < 8; a++) load(6, a, enc(NOP, 17));
    do_reset();
    run_for(6 * N);
    peek(4);
    check("R8 halted acc frozen", dbg_acc, 6);
    check("R8 halted pc", dbg_pc, 1);
    check("R8 halted flag", dbg_halt, 1);
    peek(6);
    check("R8 unknown opcode advances pc", dbg_pc, 6);
    check("R8 unknown opcode leaves acc", dbg_acc, 0);
  endtask

  task automatic t_pc_wrap();
    for (int a = 0; a < DEPTH; a++) load(7, a, enc(NOP, 0));
    do_reset();
    run_for((DEPTH + 4) * N);
    peek(7);
    check("R9 pc wraps", dbg_pc, 4);
    check("R9 halt clear", dbg_halt, 0);
  endtask

  task automatic t_dbg_ignored();
    load(8, 0, enc(NOP, 0));
    load(8, 1, enc(NOP, 0));
    load(8, 2, enc(6'h01, 9));
    load(8, 3, enc(6'h00, 0));
    do_reset();
    @(negedge clk);
    run = 1'b1;
    dbg_we = 1'b1; dbg_ctx = CW'(8); dbg_addr = AW'(2); dbg_wdata = enc(6'h01, 33);
    repeat (2) @(negedge clk);
    dbg_we = 1'b0;
    repeat (5 * N - 2) @(negedge clk);
    run = 1'b0;
    peek(8);
    check("R10 write while running ignored", dbg_acc, 9);
    begin
      int p = int'(dbg_pc);
      repeat (5) @(negedge clk);
      #1;
      check("R10 no execution while stopped", dbg_pc, p);
    end
  endtask

  initial begin
    #1_000_000;
    n_fail++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_chk + 1, n_fail);
    $finish;
  end

  initial begin
    t_reset();
    t_rotation();
    t_one_per_turn();
    t_add_wrap();
    t_store();
    t_jump();
    t_halt();
    t_pc_wrap();
    t_dbg_ignored();
    $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end
endmodule